// File: doc/BRIEF.md
# Restoring Signed-Magnitude Divider

This block divides a signed-magnitude dividend by a signed-magnitude divisor over several clock cycles. The dividend is a sign bit plus a 2N-bit magnitude. The divisor is a sign bit plus an N-bit magnitude. The result is an N-bit quotient magnitude, an N-bit remainder magnitude, a quotient sign and a divide-overflow flag. The magnitudes are split into an upper working register and a lower quotient register. Each cycle the block shifts the pair, together with a single extra carry bit, one place left. It then tries a subtraction of the divisor and keeps the difference only when it does not go negative.

Before any step runs, the block compares the upper half of the dividend with the divisor. If the upper half is not smaller, the quotient cannot fit in N bits. In that case the block raises the overflow flag and finishes at once, with the upper half left unchanged. A zero divisor always takes this path.

A caller pulses `start` while the block is idle. It then waits for `done`. All results stay stable until the next accepted start.

Top module: `sm_restoring_div`

## Requirements
- R1: After reset, `done`, `busy` and `ovf` are all 0.
- R2: When `done` is high, `quo_sign` equals the XOR of the dividend and divisor sign bits captured at the accepted start.
- R3: If the upper N bits of the dividend magnitude are greater than or equal to the divisor magnitude, `ovf` is 1 when `done` rises, and `rem_mag` equals those upper N bits.
- R4: A divisor magnitude of zero always gives `ovf` = 1.
- R5: Otherwise `ovf` is 0, `quo_mag` equals the integer quotient and `rem_mag` equals the integer remainder of dividend magnitude over divisor magnitude, and `rem_mag` is less than the divisor.
- R6: `done` rises N+1 clock edges after the edge that accepts `start` in the no-overflow case, and 1 edge after it in the overflow case. `busy` is high in between and never high together with `done`.
- R7: Once `done` is high, it and all result outputs hold their values until the next accepted start, whatever the operand inputs do.
- R8: A `start` pulse while `busy` is high is ignored, and the running division completes with its original operands.
- R9: A dividend magnitude of 448 divided by a divisor of 17 gives quotient 26 and remainder 6.
- R10: Results stay correct when a partial remainder shifts its top bit out of the N-bit register, which happens with divisors whose most significant bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only when not busy |
| dvd_sign | input | 1 | Dividend sign |
| dvd_mag | input | 2N | Dividend magnitude |
| dvs_sign | input | 1 | Divisor sign |
| dvs_mag | input | N | Divisor magnitude |
| busy | output | 1 | Division in progress |
| done | output | 1 | Result valid; held until next accepted start |
| ovf | output | 1 | Divide overflow, including divide by zero |
| quo_sign | output | 1 | Quotient sign |
| quo_mag | output | N | Quotient magnitude |
| rem_mag | output | N | Remainder magnitude |

## Verification
A wrong carry-bit choice or a missed restore in any step corrupts one quotient bit and also leaves the remainder too large. Both faults show at the ports on the cycle `done` rises, because the remainder is then no longer smaller than the divisor. An off-by-one in the step counter shifts the whole quotient, and it also moves `done` one edge early or late, so the latency check catches it on every operation. A faulty overflow compare shows at once, one edge after start. Random operands near the overflow boundary, plus divisors with the top bit set, exercise every path within a few hundred operations.

// File: rtl/smdiv_pkg.sv
package smdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2
    } smdiv_state_e;
endpackage

// File: rtl/smdiv_sub.sv
// Trial subtraction a - b by adding the two's complement of b.
// carry = 1 means a >= b.
module smdiv_sub #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] diff,
    output logic         carry
);
    logic [N:0] sum;

    always_comb begin
        sum   = {1'b0, a} + {1'b0, ~b} + {{N{1'b0}}, 1'b1};
        diff  = sum[N-1:0];
        carry = sum[N];
    end
endmodule

// File: rtl/smdiv_step.sv
// One restoring shift-subtract step on the A/Q pair.
module smdiv_step #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] q_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] a_out,
    output logic [N-1:0] q_out
);
    logic         e_bit;
    logic [N-1:0] a_sh;
    logic [N-1:0] q_sh;
    logic [N-1:0] diff;
    logic         carry;

    always_comb begin
        e_bit = a_in[N-1];
        a_sh  = {a_in[N-2:0], q_in[N-1]};
        q_sh  = {q_in[N-2:0], 1'b0};
    end

    smdiv_sub #(.N(N)) u_sub (
        .a     (a_sh),
        .b     (b_in),
        .diff  (diff),
        .carry (carry)
    );

    always_comb begin
        if (e_bit) begin
            // shifted-out bit set: remainder certainly exceeds divisor
            a_out = diff;
            q_out = q_sh | {{(N-1){1'b0}}, 1'b1};
        end else if (carry) begin
            a_out = diff;
            q_out = q_sh | {{(N-1){1'b0}}, 1'b1};
        end else begin
            a_out = a_sh;
            q_out = q_sh;
        end
    end
endmodule

// File: rtl/sm_restoring_div.sv
module sm_restoring_div
    import smdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           dvd_sign,
    input  logic [2*N-1:0] dvd_mag,
    input  logic           dvs_sign,
    input  logic [N-1:0]   dvs_mag,
    output logic           busy,
    output logic           done,
    output logic           ovf,
    output logic           quo_sign,
    output logic [N-1:0]   quo_mag,
    output logic [N-1:0]   rem_mag
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        smdiv_state_e   st;
        logic [N-1:0]   a;
        logic [N-1:0]   q;
        logic [N-1:0]   b;
        logic [CW-1:0]  sc;
        logic           qs;
        logic           ovf;
        logic           done;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0] chk_diff;
    logic         chk_carry;
    logic [N-1:0] step_a;
    logic [N-1:0] step_q;

    smdiv_sub #(.N(N)) u_ovf_chk (
        .a     (r_q.a),
        .b     (r_q.b),
        .diff  (chk_diff),
        .carry (chk_carry)
    );

    smdiv_step #(.N(N)) u_step (
        .a_in  (r_q.a),
        .q_in  (r_q.q),
        .b_in  (r_q.b),
        .a_out (step_a),
        .q_out (step_q)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_CHECK;
                    r_d.a    = dvd_mag[2*N-1:N];
                    r_d.q    = dvd_mag[N-1:0];
                    r_d.b    = dvs_mag;
                    r_d.qs   = dvd_sign ^ dvs_sign;
                    r_d.ovf  = 1'b0;
                    r_d.done = 1'b0;
                end
            end
            ST_CHECK: begin
                // A is left untouched: the trial difference is discarded
                if (chk_carry) begin
                    r_d.ovf  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.sc = CW'(N);
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.a  = step_a;
                r_d.q  = step_q;
                r_d.sc = r_q.sc - 1'b1;
                if (r_q.sc == CW'(1)) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign ovf      = r_q.ovf;
    assign quo_sign = r_q.qs;
    assign quo_mag  = r_q.q;
    assign rem_mag  = r_q.a;

    logic unused_diff;
    assign unused_diff = ^chk_diff;
endmodule

// File: rtl/smdiv_checker.sv
module smdiv_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         dvd_sign,
    input logic         dvs_sign,
    input logic [N-1:0] dvs_mag,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic         quo_sign,
    input logic [N-1:0] quo_mag,
    input logic [N-1:0] rem_mag
);
    localparam int LW = $clog2(N + 3);

    logic [N-1:0]  cap_b;
    logic          cap_s;
    logic [LW-1:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_b <= '0;
            cap_s <= 1'b0;
            lat   <= '0;
        end else if (start && !busy) begin
            cap_b <= dvs_mag;
            cap_s <= dvd_sign ^ dvs_sign;
            lat   <= '0;
        end else if (busy) begin
            lat   <= lat + 1'b1;
        end
    end

    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> quo_sign == cap_s);

    assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_b == '0) |-> ovf);

    assert_rem_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> rem_mag < cap_b);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (lat == (ovf ? LW'(1) : LW'(N + 1))));

    assert_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(quo_mag) && $stable(rem_mag)
                              && $stable(ovf) && $stable(quo_sign)));
endmodule

bind sm_restoring_div smdiv_checker #(.N(N)) u_smdiv_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dvd_sign (dvd_sign),
    .dvs_sign (dvs_sign),
    .dvs_mag  (dvs_mag),
    .busy     (busy),
    .done     (done),
    .ovf      (ovf),
    .quo_sign (quo_sign),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag)
);

// File: tb/test_sm_restoring_div.sv
module test_sm_restoring_div;
    localparam int N          = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           dvd_sign = 1'b0;
    logic [2*N-1:0] dvd_mag = '0;
    logic           dvs_sign = 1'b0;
    logic [N-1:0]   dvs_mag = '0;
    logic           busy, done, ovf, quo_sign;
    logic [N-1:0]   quo_mag, rem_mag;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    sm_restoring_div #(.N(N)) i_sm_restoring_div (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_sign(dvd_sign), .dvd_mag(dvd_mag),
        .dvs_sign(dvs_sign), .dvs_mag(dvs_mag),
        .busy(busy), .done(done), .ovf(ovf), .quo_sign(quo_sign),
        .quo_mag(quo_mag), .rem_mag(rem_mag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ovf(input logic [2*N-1:0] m, input logic [N-1:0] d);
        return (m >> N) >= d;
    endfunction

    // Runs one division; optional stray start pulse mid-run with other operands.
    task automatic run_div(input logic ds, input logic [2*N-1:0] dm,
                           input logic vs, input logic [N-1:0] vm,
                           input bit stray, input string tag);
        int  lat;
        bit  eo;
        @(negedge clk);
        dvd_sign = ds; dvd_mag = dm; dvs_sign = vs; dvs_mag = vm; start = 1'b1;
        lat = 0;
        eo  = exp_ovf(dm, vm);
        forever begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (stray && lat == 3) begin
                start = 1'b1; dvd_mag = ~dm; dvs_mag = vm ^ 8'h5a; dvd_sign = ~ds;
            end
            if (done || lat > N + 5) break;
        end
        start = 1'b0;
        chk(lat == (eo ? 2 : N + 2), {tag, " R6 latency"}, lat, eo ? 2 : N + 2);
        chk(ovf == eo, {tag, " R3 ovf"}, ovf, eo);
        chk(quo_sign == (ds ^ vs), {tag, " R2 sign"}, quo_sign, ds ^ vs);
        if (eo) begin
            chk(rem_mag == dm[2*N-1:N], {tag, " R3 upper kept"}, rem_mag, dm[2*N-1:N]);
        end else begin
            chk(quo_mag == N'(dm / vm), {tag, " R5 quotient"}, quo_mag, dm / vm);
            chk(rem_mag == N'(dm % vm), {tag, " R5 remainder"}, rem_mag, dm % vm);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        logic [N-1:0]   q_keep, r_keep;
        logic           o_keep;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!done && !busy && !ovf, "R1 reset state", {done, busy, ovf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !ovf, "R1 after release", {done, busy, ovf}, 0);

        run_div(1'b0, 16'd448, 1'b0, 8'd17, 1'b0, "R9 448/17");
        chk(quo_mag == 8'd26 && rem_mag == 8'd6, "R9 example", {quo_mag, rem_mag}, {8'd26, 8'd6});
        run_div(1'b1, 16'd448, 1'b0, 8'd17, 1'b0, "R2 neg dividend");
        run_div(1'b1, 16'd1000, 1'b1, 8'd0, 1'b0, "R4 zero divisor");
        chk(ovf == 1'b1, "R4 zero divisor flag", ovf, 1);
        run_div(1'b0, 16'd0, 1'b0, 8'd0, 1'b0, "R4 zero by zero");
        run_div(1'b0, {8'd17, 8'd0}, 1'b1, 8'd17, 1'b0, "R3 equal boundary");
        run_div(1'b0, {8'd16, 8'hff}, 1'b0, 8'd17, 1'b0, "R3 just below");
        run_div(1'b0, 16'hfeff, 1'b0, 8'hff, 1'b0, "R10 max");
        run_div(1'b0, 16'hc123, 1'b0, 8'hc5, 1'b0, "R10 top bit");
        run_div(1'b0, 16'd5, 1'b0, 8'd1, 1'b0, "R5 divide by one");

        // R8: stray start during a run is ignored
        run_div(1'b0, 16'h1234, 1'b1, 8'h77, 1'b1, "R8 stray start");

        // R7: results hold while inputs change and start stays low
        q_keep = quo_mag; r_keep = rem_mag; o_keep = ovf;
        dvd_mag = 16'hbeef; dvs_mag = 8'h03; dvd_sign = 1'b1;
        repeat (4) @(negedge clk);
        chk(done && quo_mag == q_keep && rem_mag == r_keep && ovf == o_keep,
            "R7 hold", {quo_mag, rem_mag}, {q_keep, r_keep});

        for (int i = 0; i < 400; i++) begin
            logic [N-1:0]   vm;
            logic [2*N-1:0] dm;
            vm = N'($urandom);
            if (i % 5 == 0) begin
                dm = 16'($urandom);
            end else begin
                if (vm == 0) vm = 8'd1;
                if (i % 7 == 0) vm[N-1] = 1'b1;
                dm = {N'($urandom % vm), N'($urandom)};
            end
            run_div(1'($urandom), dm, 1'($urandom), vm, (i % 50 == 0), "R5 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule